// File: doc/BRIEF.md
# I2C Bus Monitor with Address Classification

This block watches the two wires of an I2C bus without ever driving them. Both lines are first brought into the local clock domain through a chain of synchronizer flops. Start and stop conditions are then recognised from consecutive synchronized samples: an SDA edge while SCL is high. A bus-busy flag covers the span between a start and the following stop.

After every start, including a repeated start, the monitor collects the first byte on the bus. It samples one bit on each rising SCL edge, most significant bit first. The first seven bits form the target address and the eighth is the read/write bit. On the ninth rising SCL edge it records the acknowledge level and raises a one-cycle address-valid pulse. It also sorts the captured address into one of four classes: ordinary, general call, null/CBUS, or address extension. Later data bytes are ignored. A stop that arrives before the ninth bit discards the partial byte.

Top module: `i2c_bus_observer`

## Requirements
- R1: While reset is held and right after it is released, every output is low and the address, read/write, acknowledge and class outputs are zero.
- R2: SDA falling while SCL stays high produces a one-clock `start_pulse`. The pulse is registered 3 clock edges after the first edge that samples the falling SDA.
- R3: SDA rising while SCL stays high produces a one-clock `stop_pulse`, with the same latency as R2. `start_pulse` and `stop_pulse` are never high together.
- R4: `bus_busy` goes high with `start_pulse` and stays high, repeated starts included, until it drops with `stop_pulse`.
- R5: SDA changing while SCL is low produces no start or stop pulse.
- R6: After a start, the bits sampled on the first eight rising SCL edges are shifted in MSB first. Bits 7..1 appear on `addr_out` and bit 0 on `rw_out` (1 = read). `addr_valid` pulses for one clock on the ninth rising SCL edge.
- R7: `ack_out` is 1 (ACK) when SDA is low on that ninth rising SCL edge, and 0 (NACK) otherwise.
- R8: `addr_class` is 1 for address 0000000 (general call), 2 for 0000001 (null/CBUS), 3 for any 1111xxx (address extension), and 0 for every other address.
- R9: Bytes that follow the address byte within the same transfer produce no `addr_valid` and leave the captured outputs unchanged.
- R10: A repeated start restarts the bit count, and the next byte is captured as a new address.
- R11: A stop before the ninth rising SCL edge aborts the capture. No `addr_valid` pulse occurs and the captured outputs keep their previous values.
- R12: `addr_out`, `rw_out`, `ack_out` and `addr_class` change only in the cycle in which `addr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| start_pulse | output | 1 | One-clock pulse on a start or repeated start |
| stop_pulse | output | 1 | One-clock pulse on a stop |
| bus_busy | output | 1 | High from a start until a stop |
| addr_valid | output | 1 | One-clock pulse when an address byte and its acknowledge are complete |
| addr_out | output | 7 | Last captured address |
| rw_out | output | 1 | Last captured read/write bit, 1 = read |
| ack_out | output | 1 | 1 = acknowledged, 0 = not acknowledged |
| addr_class | output | 2 | 0 ordinary, 1 general call, 2 null/CBUS, 3 extension |

## Verification
Every result is registered exactly once after the synchronizer chain. An SCL or SDA change therefore shows up on the pulses, on `bus_busy` and on the captured fields three clock edges after the first edge that samples it. The bench keeps the raw line levels it drove at each rising edge in a short history and evaluates its behavioural model on the sample taken three edges earlier. It then compares every output on the falling edge, away from the edge where the design updates. Directed checks made a few cycles after each bus phase confirm the classes, the acknowledge values and the absence of pulses in the glitch, data-byte and aborted-byte cases.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_GCALL = 2'd1,
    CLS_NULL  = 2'd2,
    CLS_EXT   = 2'd3
  } addr_cls_e;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_t;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 scl_raw,
  input  logic                 sda_raw,
  output logic                 rst_n_int,
  output i2cmon_pkg::line_t    now_s,
  output i2cmon_pkg::line_t    prev_s
);
  import i2cmon_pkg::*;

  logic [1:0] rst_pipe_q;
  line_t      chain_q [STAGES];
  line_t      prev_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      line_t d_in;
      if (g == 0) begin : g_first
        assign d_in = '{scl: scl_raw, sda: sda_raw};
      end else begin : g_next
        assign d_in = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n_int) begin
        if (!rst_n_int) chain_q[g] <= '{scl: 1'b1, sda: 1'b1};
        else            chain_q[g] <= d_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) prev_q <= '{scl: 1'b1, sda: 1'b1};
    else            prev_q <= chain_q[STAGES-1];
  end

  assign now_s  = chain_q[STAGES-1];
  assign prev_s = prev_q;

endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond (
  input  logic               clk,
  input  logic               rst_n,
  input  i2cmon_pkg::line_t  now_s,
  input  i2cmon_pkg::line_t  prev_s,
  output logic               start_det,
  output logic               stop_det,
  output logic               rise_det,
  output logic               start_q,
  output logic               stop_q,
  output logic               busy_q
);
  logic scl_held_high;
  logic busy_d;

  always_comb begin
    scl_held_high = prev_s.scl & now_s.scl;
    start_det     = scl_held_high &  prev_s.sda & ~now_s.sda;
    stop_det      = scl_held_high & ~prev_s.sda &  now_s.sda;
    rise_det      = ~prev_s.scl & now_s.scl;
    busy_d        = busy_q;
    if (start_det)     busy_d = 1'b1;
    else if (stop_det) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= start_det;
      stop_q  <= stop_det;
      busy_q  <= busy_d;
    end
  end

  // R3
  cond_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && stop_q));

  // R4
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q);

  // R4
  stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !busy_q);

endmodule

// File: rtl/i2cmon_capture.sv
module i2cmon_capture #(
  parameter int ADDR_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               rise_det,
  input  logic               sda_bit,
  output logic               valid_q,
  output logic [ADDR_W-1:0]  addr_q,
  output logic               rw_q,
  output logic               ack_q,
  output logic [1:0]         cls_q
);
  import i2cmon_pkg::*;

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              cap_q, cap_d;
  logic              valid_d;
  logic              shift_en;
  addr_cls_e         cls_d;

  function automatic addr_cls_e classify(input logic [ADDR_W-1:0] a);
    if (a == '0)                            return CLS_GCALL;
    else if (a == ADDR_W'(1))               return CLS_NULL;
    else if (&a[ADDR_W-1 -: 4])             return CLS_EXT;
    else                                    return CLS_PLAIN;
  endfunction

  always_comb begin
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    cap_d    = cap_q;
    valid_d  = 1'b0;
    shift_en = 1'b0;
    cls_d    = classify(sh_q[BYTE_W-1:1]);
    if (start_det) begin
      cap_d = 1'b1;
      cnt_d = '0;
    end else if (stop_det) begin
      cap_d = 1'b0;
      cnt_d = '0;
    end else if (rise_det && cap_q) begin
      if (cnt_q < LAST_BIT) begin
        shift_en = 1'b1;
        sh_d     = {sh_q[BYTE_W-2:0], sda_bit};
        cnt_d    = cnt_q + 1'b1;
      end else begin
        valid_d = 1'b1;
        cap_d   = 1'b0;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cap_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cap_q   <= cap_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rw_q   <= 1'b0;
      ack_q  <= 1'b0;
      cls_q  <= 2'd0;
    end else if (valid_d) begin
      addr_q <= sh_q[BYTE_W-1:1];
      rw_q   <= sh_q[0];
      ack_q  <= ~sda_bit;
      cls_q  <= cls_d;
    end
  end

  // R6
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_BIT);

  // R12
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(addr_q) && $stable(rw_q) && $stable(ack_q) && $stable(cls_q)));

  // R11
  abort_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !valid_q);

endmodule

// File: rtl/i2c_bus_observer.sv
module i2c_bus_observer #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic              bus_busy,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out,
  output logic              rw_out,
  output logic              ack_out,
  output logic [1:0]        addr_class
);
  import i2cmon_pkg::*;

  logic  rst_n_int;
  line_t now_s, prev_s;
  logic  start_det, stop_det, rise_det;

  i2cmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .arst_n    (rst_n),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .rst_n_int (rst_n_int),
    .now_s     (now_s),
    .prev_s    (prev_s)
  );

  i2cmon_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .now_s     (now_s),
    .prev_s    (prev_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rise_det  (rise_det),
    .start_q   (start_pulse),
    .stop_q    (stop_pulse),
    .busy_q    (bus_busy)
  );

  i2cmon_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rise_det  (rise_det),
    .sda_bit   (now_s.sda),
    .valid_q   (addr_valid),
    .addr_q    (addr_out),
    .rw_q      (rw_out),
    .ack_q     (ack_out),
    .cls_q     (addr_class)
  );

  // R9
  valid_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    addr_valid |-> bus_busy);

  // R2
  valid_not_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    addr_valid |-> !start_pulse);

endmodule

// File: tb/tb_i2c_bus_observer.sv
module tb_i2c_bus_observer;
  localparam int SYNC = 2;
  localparam int H    = 6;

  logic clk, rst_n, scl_in, sda_in;
  logic start_pulse, stop_pulse, bus_busy, addr_valid, rw_out, ack_out;
  logic [6:0] addr_out;
  logic [1:0] addr_class;

  i2c_bus_observer #(.SYNC_STAGES(SYNC), .ADDR_W(7)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .bus_busy(bus_busy),
    .addr_valid(addr_valid), .addr_out(addr_out), .rw_out(rw_out),
    .ack_out(ack_out), .addr_class(addr_class)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int n_start = 0, n_stop = 0, n_valid = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  logic [1:0] hist[$];
  bit m_busy, m_start, m_stop, m_valid, m_rw, m_ack, m_cap;
  int m_addr, m_cls, m_cnt, m_sh;
  bit model_on = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cls_of(input int a);
    if (a == 0) return 1;
    if (a == 1) return 2;
    if ((a >> 3) == 15) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < 8; i++) hist.push_back(2'b11);
      m_busy = 0; m_start = 0; m_stop = 0; m_valid = 0; m_rw = 0; m_ack = 0;
      m_cap = 0; m_addr = 0; m_cls = 0; m_cnt = 0; m_sh = 0;
    end else begin
      logic [1:0] c, p;
      hist.push_back({scl_in, sda_in});
      if (hist.size() > 8) void'(hist.pop_front());
      c = hist[hist.size()-2-SYNC+1];
      p = hist[hist.size()-3-SYNC+1];
      m_start = p[1] && c[1] && p[0] && !c[0];
      m_stop  = p[1] && c[1] && !p[0] && c[0];
      m_valid = 0;
      if (m_start) begin m_busy = 1; m_cap = 1; m_cnt = 0; end
      else if (m_stop) begin m_busy = 0; m_cap = 0; m_cnt = 0; end
      else if (!p[1] && c[1] && m_cap) begin
        if (m_cnt < 8) begin m_sh = ((m_sh << 1) | c[0]) & 8'hFF; m_cnt++; end
        else begin
          m_valid = 1; m_addr = m_sh >> 1; m_rw = m_sh[0]; m_ack = !c[0];
          m_cls = cls_of(m_addr); m_cap = 0; m_cnt = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && model_on && !done) begin
      check(start_pulse == m_start, "R2 start_pulse", start_pulse, m_start);
      check(stop_pulse == m_stop, "R3 stop_pulse", stop_pulse, m_stop);
      check(bus_busy == m_busy, "R4 bus_busy", bus_busy, m_busy);
      check(addr_valid == m_valid, "R6 addr_valid", addr_valid, m_valid);
      check(addr_out == m_addr[6:0], m_valid ? "R6 addr_out" : "R12 addr_out hold", addr_out, m_addr);
      check(rw_out == m_rw, "R6 rw_out", rw_out, m_rw);
      check(ack_out == m_ack, "R7 ack_out", ack_out, m_ack);
      check(addr_class == m_cls[1:0], "R8 addr_class", addr_class, m_cls);
      if (start_pulse) n_start++;
      if (stop_pulse)  n_stop++;
      if (addr_valid)  n_valid++;
    end
  end

  task automatic hold(); repeat (H) @(negedge clk); endtask
  task automatic drv_start();
    sda_in = 1; hold(); scl_in = 1; hold(); sda_in = 0; hold(); scl_in = 0; hold();
  endtask
  task automatic drv_stop();
    sda_in = 0; hold(); scl_in = 1; hold(); sda_in = 1; hold();
  endtask
  task automatic drv_bit(input bit b);
    sda_in = b; hold(); scl_in = 1; hold(); scl_in = 0; hold();
  endtask
  task automatic drv_byte(input logic [7:0] v, input bit ack_lvl);
    for (int i = 7; i >= 0; i--) drv_bit(v[i]);
    drv_bit(ack_lvl);
  endtask

  initial begin
    int sv, ss, sa;
    rst_n = 0; scl_in = 1; sda_in = 1;
    repeat (4) @(negedge clk);
    check(!start_pulse && !stop_pulse && !bus_busy && !addr_valid, "R1 pulses in reset",
          {start_pulse, stop_pulse, bus_busy, addr_valid}, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    check(addr_out == 0 && !rw_out && !ack_out && addr_class == 0 && !bus_busy,
          "R1 fields after reset", {addr_out, rw_out, ack_out, addr_class}, 0);
    model_on = 1;

    // write to 0x50, acked, one data byte
    drv_start();
    check(bus_busy == 1, "R4 busy after start", bus_busy, 1);
    drv_byte({7'h50, 1'b0}, 1'b0);
    check(addr_out == 7'h50 && ack_out == 1 && addr_class == 0, "R6 R7 plain write",
          {addr_out, ack_out}, {7'h50, 1'b1});
    sv = n_valid;
    drv_byte(8'h00, 1'b0);
    check(n_valid == sv && addr_out == 7'h50, "R9 data byte ignored", n_valid - sv, 0);
    drv_stop(); hold();
    check(bus_busy == 0, "R4 idle after stop", bus_busy, 0);

    // general call read, NACK
    drv_start(); drv_byte({7'h00, 1'b1}, 1'b1);
    check(addr_class == 1 && rw_out == 1 && ack_out == 0, "R8 R7 general call nack",
          {addr_class, rw_out, ack_out}, {2'd1, 2'b10});
    drv_stop(); hold();

    // null address
    drv_start(); drv_byte({7'h01, 1'b0}, 1'b0);
    check(addr_class == 2, "R8 null class", addr_class, 2);
    drv_stop(); hold();

    // extension address, then repeated start to 0x23
    drv_start(); drv_byte({7'h7A, 1'b0}, 1'b0);
    check(addr_class == 3, "R8 extension class", addr_class, 3);
    sv = n_valid;
    drv_start();
    check(bus_busy == 1, "R4 busy across repeated start", bus_busy, 1);
    drv_byte({7'h23, 1'b1}, 1'b0);
    check(n_valid == sv + 1 && addr_out == 7'h23 && addr_class == 0, "R10 repeated start capture",
          addr_out, 7'h23);
    drv_stop(); hold();

    // SDA wiggle with SCL low
    ss = n_start; sa = n_stop;
    scl_in = 0; hold();
    for (int k = 0; k < 5; k++) begin sda_in = ~sda_in; hold(); end
    sda_in = 1; hold(); scl_in = 1; hold(); hold();
    check(n_start == ss && n_stop == sa, "R5 no events while SCL low",
          n_start + n_stop - ss - sa, 0);

    // aborted address byte
    sv = n_valid;
    drv_start();
    for (int k = 0; k < 4; k++) drv_bit(k[0]);
    drv_stop(); hold();
    check(n_valid == sv && addr_out == 7'h23 && bus_busy == 0, "R11 aborted byte",
          n_valid - sv, 0);

    // stop while idle, then a fresh extension address
    drv_stop(); hold();
    check(n_stop > sa, "R3 stop seen", n_stop, sa + 1);
    drv_start(); drv_byte({7'h78, 1'b1}, 1'b0);
    check(addr_out == 7'h78 && addr_class == 3 && rw_out == 1, "R8 extension 1111000",
          addr_out, 7'h78);
    drv_stop(); hold(); hold();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule